// File: doc/BRIEF.md
# Full/Empty Synchronizing Word Memory

This block is a word-addressed storage array in which each 32-bit word is paired with a presence flag that marks it as full or empty. Producer and consumer threads use it for fine-grained synchronization.

A consumer can wait for a word, or take it and leave the slot empty. A producer can deposit a word, or deposit it only into an empty slot. When an access meets the wrong flag state, the block reports a trap instead of completing the access. Software above the block decides what to do about the trap, for example retry the access or switch threads.

The block accepts one request per cycle, made of an opcode, a word address and write data. Each access reads the word and its flag, decides the outcome, and writes back the new data and flag in a single atomic step. The result appears exactly one cycle later, as a valid strobe, the read data and a trap flag. Flags are stored in groups of four, one group per line of four neighbouring words.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every word reads as zero, every flag is empty, and `rspValid` and `rspTrap` are low.
- R2: `rspValid` is high in the cycle after a cycle with `reqValid` high, and low in the cycle after a cycle with `reqValid` low.
- R3: Plain load (opcode 0) returns the stored word, never traps, and leaves the flag unchanged.
- R4: Plain store (opcode 1) writes the word, never traps, returns zero data, and leaves the flag unchanged.
- R5: Wait-load (opcode 2) returns the word and keeps the flag full when the word is full. When the word is empty it traps and returns zero data.
- R6: Take-load (opcode 3) returns the word and marks it empty when the word is full. When the word is empty it traps.
- R7: Fill-store (opcode 4) writes the word and marks it full whatever the prior flag, and never traps.
- R8: Exclusive fill-store (opcode 5) traps without writing when the word is full. Otherwise it writes the word and marks it full.
- R9: An access that traps changes neither the stored word nor its flag.
- R10: Opcodes 6 and 7 behave as a plain load.
- R11: A request to the same word in the very next cycle sees the data and flag left by the previous request.
- R12: Each line of four words (address bits 7:2) keeps its four flags together, and changing one word's flag leaves the other three words' flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Access opcode |
| reqAddr | input | 8 | Word address |
| reqWrData | input | 32 | Data for store opcodes |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspData | output | 32 | Read data; zero for stores and traps |
| rspTrap | output | 1 | Access found the flag in the wrong state |

## Verification
A corrupted flag does not show up on the access that damages it. It only shows up on the next flag-testing access to that word. At that point a wait-load or take-load traps when it should return data, or an exclusive fill passes when it should trap.

For this reason the bench follows each state-changing access with a probe of the same word, usually in the very next cycle, so that a wrong flag or a lost write appears at most two cycles later. Probes of neighbouring words in the same line show flags that leak between lanes.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

  typedef enum logic [2:0] {
    OP_LOAD       = 3'd0,
    OP_STORE      = 3'd1,
    OP_LOAD_WAIT  = 3'd2,
    OP_LOAD_TAKE  = 3'd3,
    OP_STORE_FILL = 3'd4,
    OP_STORE_EXCL = 3'd5
  } fe_op_e;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic access;     // a request is being served
    logic writeWord;  // store reqWrData into the word
    logic flagWrite;  // update the presence flag
    logic flagValue;  // new flag value, 1 = full
    logic trap;       // wrong flag state, suppress everything
    logic returnWord; // put the stored word on the response
  } fe_strobe_t;

endpackage

// File: rtl/fe_mem_ctrl.sv
module fe_mem_ctrl
  import fe_mem_pkg::*;
(
  input  logic       reqValid,
  input  fe_op_e     reqOp,
  input  logic       wordFull,
  output fe_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    strobe.access = reqValid;
    if (reqValid) begin
      case (reqOp)
        OP_STORE: strobe.writeWord = 1'b1;
        OP_LOAD_WAIT: begin
          if (wordFull) strobe.returnWord = 1'b1;
          else          strobe.trap = 1'b1;
        end
        OP_LOAD_TAKE: begin
          if (wordFull) begin
            strobe.returnWord = 1'b1;
            strobe.flagWrite  = 1'b1;
            strobe.flagValue  = 1'b0;
          end else begin
            strobe.trap = 1'b1;
          end
        end
        OP_STORE_FILL: begin
          strobe.writeWord = 1'b1;
          strobe.flagWrite = 1'b1;
          strobe.flagValue = 1'b1;
        end
        OP_STORE_EXCL: begin
          if (wordFull) begin
            strobe.trap = 1'b1;
          end else begin
            strobe.writeWord = 1'b1;
            strobe.flagWrite = 1'b1;
            strobe.flagValue = 1'b1;
          end
        end
        default: strobe.returnWord = 1'b1; // plain load and spare codes
      endcase
    end
  end

endmodule

// File: rtl/fe_mem_datapath.sv
module fe_mem_datapath
  import fe_mem_pkg::*;
#(
  parameter int unsigned WORDS      = 256,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_WORDS = 4,
  localparam int unsigned ADDR_W    = $clog2(WORDS),
  localparam int unsigned LANE_W    = $clog2(LINE_WORDS),
  localparam int unsigned LINES     = WORDS / LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  fe_strobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              wordFull,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspTrap
);

  logic [DATA_W-1:0]     dataArray [WORDS];
  logic [LINE_WORDS-1:0] flagLines [LINES];

  logic [ADDR_W-LANE_W-1:0] lineIdx;
  logic [LANE_W-1:0]        laneIdx;

  assign lineIdx  = reqAddr[ADDR_W-1:LANE_W];
  assign laneIdx  = reqAddr[LANE_W-1:0];
  assign wordFull = flagLines[lineIdx][laneIdx];

  // One flag register group per line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic lineHit;
    assign lineHit = strobe.flagWrite && (lineIdx == (ADDR_W-LANE_W)'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagLines[g] <= '0;
      end else if (lineHit) begin
        flagLines[g][laneIdx] <= strobe.flagValue;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) dataArray[i] <= '0;
    end else if (strobe.writeWord) begin
      dataArray[reqAddr] <= reqWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTrap  <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.access;
      rspTrap  <= strobe.trap;
      rspData  <= strobe.returnWord ? dataArray[reqAddr] : '0;
    end
  end

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_mem_pkg::*;
#(
  parameter int unsigned WORDS      = 256,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_WORDS = 4,
  localparam int unsigned ADDR_W    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspTrap
);

  fe_strobe_t strobe;
  logic       wordFull;

  fe_mem_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqOp    (fe_op_e'(reqOp)),
    .wordFull (wordFull),
    .strobe   (strobe)
  );

  fe_mem_datapath #(
    .WORDS      (WORDS),
    .DATA_W     (DATA_W),
    .LINE_WORDS (LINE_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWrData (reqWrData),
    .wordFull  (wordFull),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .rspTrap   (rspTrap)
  );

endmodule

// File: rtl/fe_sync_mem_checker.sv
module fe_sync_mem_checker
  import fe_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              rspTrap
);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspTrap);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_plain_load_no_trap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'(OP_LOAD)) |=> !rspTrap);

  p_plain_store_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'(OP_STORE)) |=> (!rspTrap && rspData == '0));

  p_trap_no_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTrap) |-> rspData == '0);

  p_take_twice_traps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'(OP_LOAD_TAKE) && $past(reqValid)
     && $past(reqOp) == 3'(OP_LOAD_TAKE) && reqAddr == $past(reqAddr)) |=> rspTrap);

  p_fill_no_trap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'(OP_STORE_FILL)) |=> !rspTrap);

  p_fill_then_excl_traps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'(OP_STORE_EXCL) && $past(reqValid)
     && $past(reqOp) == 3'(OP_STORE_FILL) && reqAddr == $past(reqAddr)) |=> rspTrap);

endmodule

bind fe_sync_mem fe_sync_mem_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspData  (rspData),
  .rspTrap  (rspTrap)
);

// File: tb/fe_sync_mem_test.sv
`timescale 1ns/1ps
module fe_sync_mem_test;
  import fe_mem_pkg::*;

  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWrData = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspTrap;

  always #5 clk = ~clk;

  fe_sync_mem uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWrData(reqWrData),
    .rspValid(rspValid), .rspData(rspData), .rspTrap(rspTrap)
  );

  typedef struct {
    bit          valid;
    logic [31:0] data;
    bit          trap;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] mData [WORDS];
  bit          mFull [WORDS];
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: drive one request and push its expected response
  task automatic issue(fe_op_e op, int addr, logic [31:0] wd, string tag);
    exp_t e;
    bit full;
    @(negedge clk);
    reqValid  = 1'b1;
    reqOp     = op;
    reqAddr   = addr[7:0];
    reqWrData = wd;
    full = mFull[addr];
    e.valid = 1'b1; e.data = '0; e.trap = 1'b0; e.tag = tag;
    case (op)
      OP_STORE: mData[addr] = wd;
      OP_LOAD_WAIT: if (full) e.data = mData[addr]; else e.trap = 1'b1;
      OP_LOAD_TAKE: if (full) begin e.data = mData[addr]; mFull[addr] = 1'b0; end
                    else e.trap = 1'b1;
      OP_STORE_FILL: begin mData[addr] = wd; mFull[addr] = 1'b1; end
      OP_STORE_EXCL: if (full) e.trap = 1'b1;
                     else begin mData[addr] = wd; mFull[addr] = 1'b1; end
      default: e.data = mData[addr];
    endcase
    expQ.push_back(e);
  endtask

  task automatic issueRaw(logic [2:0] code, int addr, string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqOp = code; reqAddr = addr[7:0]; reqWrData = 32'hDEAD_0000;
    e.valid = 1'b1; e.data = mData[addr]; e.trap = 1'b0; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b0;
    e.valid = 1'b0; e.data = '0; e.trap = 1'b0; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare registered responses just after each rising edge
  initial begin
    exp_t e;
    wait (rstN);
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        check(rspValid == e.valid, e.tag, "rspValid", 32'(rspValid), 32'(e.valid));
        if (e.valid) begin
          check(rspTrap == e.trap, e.tag, "rspTrap", 32'(rspTrap), 32'(e.trap));
          check(rspData == e.data, e.tag, "rspData", rspData, e.data);
        end
      end else if (rspValid) begin
        check(1'b0, "R2", "unexpected rspValid", 32'(rspValid), 32'd0);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin mData[i] = '0; mFull[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, "R1", "rspValid in reset", 32'(rspValid), 32'd0);
    check(rspTrap == 1'b0, "R1", "rspTrap in reset", 32'(rspTrap), 32'd0);
    rstN = 1'b1;

    // R1 reset contents, R5 wait on empty
    issue(OP_LOAD_WAIT, 0, '0, "R1_R5 empty after reset w0");
    issue(OP_LOAD_WAIT, 1, '0, "R1_R5 empty after reset w1");
    issue(OP_LOAD_WAIT, 255, '0, "R1_R5 empty after reset w255");
    issue(OP_LOAD, 3, '0, "R1_R3 zero after reset");
    idle("R2 idle gap");

    // R4 plain store leaves flag empty
    issue(OP_STORE, 10, 32'h1111_AAAA, "R4 plain store");
    issue(OP_LOAD_WAIT, 10, '0, "R4 flag still empty");
    issue(OP_LOAD, 10, '0, "R3 plain load sees store");

    // R7 fill, R5 wait keeps full, R4 store keeps full
    issue(OP_STORE_FILL, 10, 32'h2222_BBBB, "R7 fill");
    issue(OP_LOAD_WAIT, 10, '0, "R5_R11 wait on full");
    issue(OP_LOAD_WAIT, 10, '0, "R5 wait keeps full");
    issue(OP_STORE, 10, 32'h3333_CCCC, "R4 store on full");
    issue(OP_LOAD_WAIT, 10, '0, "R4 flag still full");

    // R6 take then take again
    issue(OP_LOAD_TAKE, 10, '0, "R6 take full");
    issue(OP_LOAD_TAKE, 10, '0, "R6_R11 take empty traps");
    issue(OP_LOAD, 10, '0, "R9 data kept after trap");
    idle("R2 idle gap");

    // R8 exclusive fill
    issue(OP_STORE_EXCL, 10, 32'h4444_DDDD, "R8 excl on empty");
    issue(OP_STORE_EXCL, 10, 32'h5555_EEEE, "R8_R11 excl on full traps");
    issue(OP_LOAD, 10, '0, "R9 excl trap kept data");
    issue(OP_LOAD_WAIT, 10, '0, "R9 excl trap kept flag");
    issue(OP_STORE_FILL, 10, 32'h6666_FFFF, "R7 fill over full");
    issue(OP_LOAD, 10, '0, "R7 fill over full data");

    // R9 wait trap keeps data
    issue(OP_STORE, 40, 32'h0BAD_CAFE, "R4 store to empty");
    issue(OP_LOAD_WAIT, 40, '0, "R9 wait traps");
    issue(OP_LOAD, 40, '0, "R9 wait trap kept data");

    // R12 lanes of one line
    issue(OP_STORE_FILL, 20, 32'h0000_0020, "R12 fill lane0");
    issue(OP_LOAD_WAIT, 21, '0, "R12 lane1 empty");
    issue(OP_LOAD_WAIT, 22, '0, "R12 lane2 empty");
    issue(OP_LOAD_WAIT, 23, '0, "R12 lane3 empty");
    issue(OP_LOAD_WAIT, 16, '0, "R12 previous line empty");
    issue(OP_STORE_FILL, 23, 32'h0000_0023, "R12 fill lane3");
    issue(OP_LOAD_TAKE, 20, '0, "R12 take lane0");
    issue(OP_LOAD_WAIT, 23, '0, "R12 lane3 still full");

    // R10 spare codes
    issueRaw(3'd6, 23, "R10 code 6 as load");
    issueRaw(3'd7, 23, "R10 code 7 as load");
    issue(OP_LOAD_WAIT, 23, '0, "R10 spare codes keep flag");
    idle("R2 idle gap");
    idle("R2 idle gap 2");

    // Sweep: fill, take, take again
    for (int i = 0; i < 64; i++) issue(OP_STORE_FILL, 64 + i, 32'hA500_0000 + 32'(i * 7), "R7 sweep fill");
    for (int i = 0; i < 64; i++) issue(OP_LOAD_TAKE, 64 + i, '0, "R6 sweep take");
    for (int i = 0; i < 64; i++) issue(OP_LOAD_TAKE, 64 + i, '0, "R6 sweep take empty");
    for (int i = 0; i < 8; i++) issue(OP_STORE_EXCL, 200 + i, 32'h7700_0000 + 32'(i), "R8 sweep excl");
    for (int i = 0; i < 8; i++) issue(OP_LOAD_WAIT, 200 + i, '0, "R8 sweep check");

    idle("R2 final idle");
    repeat (3) @(posedge clk);
    #3;
    check(expQ.size() == 0, "R2", "responses drained", 32'(expQ.size()), 32'd0);
    finishRun();
  end

endmodule